// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This combinational unit decides which NaN a single-precision operation returns when its inputs make the result a NaN. It serves operations with one, two or three operands; the three-operand case is fused multiply-add, with operands a and b as the product and c as the addend. The operand encodings come in alongside classes that upstream logic has already computed. A mode bit can replace every NaN result with the canonical default NaN. A separate indicator tells the unit that a multiply-add has an infinity times zero product.

The unit returns the 32-bit NaN result and an invalid-operation flag. The flag is raised when a signalling NaN is among the operands in use, or when a multiply-add has an infinity times zero product. A signalling NaN that is selected leaves the unit quieted: fraction bit 22 is set, and the sign and the remaining payload bits are kept. The surrounding datapath enables the unit only when at least one operand in use is a NaN, or, for multiply-add, when the product is infinity times zero.

Top module: `fpnan_select`

## Requirements
- R1: `invalid_out` is 1 exactly when an operand in use has class code 4 (signalling NaN), or when the operation has three operands and `inf_zero` is 1. The class codes are 0 zero, 1 finite non-zero, 2 infinity, 3 quiet NaN and 4 signalling NaN. `op_count` 0 or 1 uses operand a only, 2 uses a and b, and 3 uses a, b and c.
- R2: With one operand, a quiet NaN is returned unchanged. A signalling NaN is returned with bit 22 set and every other bit unchanged.
- R3: With `dflt_mode` at 1, the result is 0x7FC00000 for every operand count.
- R4: With two operands, when only one is a NaN, that NaN is returned. When one is signalling and the other is quiet, the signalling one wins.
- R5: With two operands of the same NaN kind, the one with the larger 23-bit fraction wins.
- R6: With two operands of the same NaN kind and equal fractions, the one with sign bit 0 wins.
- R7: A signalling NaN selected from two operands is returned with bit 22 set and its sign and other fraction bits kept.
- R8: With three operands, `inf_zero` at 1 gives 0x7FC00000 and raises invalid, even when c is a quiet NaN.
- R9: With three operands, no `inf_zero` and c a NaN, c is returned (quieted if it is signalling), whatever a and b hold.
- R10: With three operands, no `inf_zero` and c not a NaN, the first signalling NaN in the order a, b is returned quieted. If neither is signalling, the first NaN in the order a, b is returned.
- R11: With three operands, no `inf_zero` and no NaN among them, the result is 0x7FC00000.
- R12: Operands that are not in use (b with one operand, c with one or two operands) have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_count | input | 2 | Number of operands in use (0 or 1 means one operand) |
| opnd_a | input | 32 | Operand a encoding |
| opnd_b | input | 32 | Operand b encoding |
| opnd_c | input | 32 | Operand c encoding (addend) |
| cls_a | input | 3 | Class code of a |
| cls_b | input | 3 | Class code of b |
| cls_c | input | 3 | Class code of c |
| dflt_mode | input | 1 | Force the default NaN |
| inf_zero | input | 1 | Multiply-add product is infinity times zero |
| nan_out | output | 32 | Selected NaN result |
| invalid_out | output | 1 | Invalid-operation flag |

## Verification
The unit has no storage, so a wrong selection or a lost quieting step shows on `nan_out` in the same evaluation as the inputs that cause it. A wrong priority shows up as the wrong operand's payload or sign. A missed quieting step shows up as bit 22 clear in the result. The bench sweeps every combination of operand classes for each operand count, mode and indicator value. It uses payloads and signs that force fraction ties and sign tie-breaks. Each check compares the result with a key-ordering model.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NORM = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        PICK_A    = 2'd0,
        PICK_B    = 2'd1,
        PICK_C    = 2'd2,
        PICK_DFLT = 2'd3
    } pick_e;

    localparam int NUM_OPND = 3;

    function automatic logic cls_is_nan(input logic [2:0] c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic cls_is_snan(input logic [2:0] c);
        return c == CLS_SNAN;
    endfunction

endpackage

// File: rtl/fpnan_pick2.sv
module fpnan_pick2
    import fpnan_pkg::*;
#(
    parameter int FRAC_W = 23
) (
    input  logic              sign_a,
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [2:0]        cls_a,
    input  logic              sign_b,
    input  logic [FRAC_W-1:0] frac_b,
    input  logic [2:0]        cls_b,
    output pick_e             sel
);
    logic a_nan, b_nan, a_sig, b_sig;

    always_comb begin
        a_nan = cls_is_nan(cls_a);
        b_nan = cls_is_nan(cls_b);
        a_sig = cls_is_snan(cls_a);
        b_sig = cls_is_snan(cls_b);
        sel   = PICK_A;
        if (a_nan && !b_nan) begin
            sel = PICK_A;
        end else if (b_nan && !a_nan) begin
            sel = PICK_B;
        end else if (a_nan && b_nan) begin
            if (a_sig != b_sig) begin
                sel = a_sig ? PICK_A : PICK_B;
            end else if (frac_a != frac_b) begin
                sel = (frac_a > frac_b) ? PICK_A : PICK_B;
            end else if (sign_a != sign_b) begin
                sel = sign_a ? PICK_B : PICK_A;
            end else begin
                sel = PICK_A;
            end
        end
    end
endmodule

// File: rtl/fpnan_pick3.sv
module fpnan_pick3
    import fpnan_pkg::*;
(
    input  logic [2:0] cls_a,
    input  logic [2:0] cls_b,
    input  logic [2:0] cls_c,
    input  logic       inf_zero,
    output pick_e      sel
);
    always_comb begin
        if (inf_zero) begin
            sel = PICK_DFLT;
        end else if (cls_is_nan(cls_c)) begin
            sel = PICK_C;
        end else if (cls_is_snan(cls_a)) begin
            sel = PICK_A;
        end else if (cls_is_snan(cls_b)) begin
            sel = PICK_B;
        end else if (cls_is_nan(cls_a)) begin
            sel = PICK_A;
        end else if (cls_is_nan(cls_b)) begin
            sel = PICK_B;
        end else begin
            sel = PICK_DFLT;
        end
    end
endmodule

// File: rtl/fpnan_finish.sv
module fpnan_finish
    import fpnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [2:0]        cls_in,
    input  logic              force_dflt,
    output logic [WORD_W-1:0] word_out
);
    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
    localparam logic [WORD_W-1:0] DFLT_NAN  =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    always_comb begin
        if (force_dflt) begin
            word_out = DFLT_NAN;
        end else if (cls_is_snan(cls_in)) begin
            word_out = word_in | QUIET_BIT;
        end else begin
            word_out = word_in;
        end
    end
endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
    import fpnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [1:0]        op_count,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] opnd_c,
    input  logic [2:0]        cls_a,
    input  logic [2:0]        cls_b,
    input  logic [2:0]        cls_c,
    input  logic              dflt_mode,
    input  logic              inf_zero,
    output logic [WORD_W-1:0] nan_out,
    output logic              invalid_out
);
    logic [WORD_W-1:0] words [NUM_OPND];
    logic [2:0]        clses [NUM_OPND];
    logic [NUM_OPND-1:0] in_use;
    logic [NUM_OPND-1:0] sig_hit;
    logic is_two, is_three;
    pick_e sel2, sel3, sel;
    logic [WORD_W-1:0] chosen_word;
    logic [2:0]        chosen_cls;

    assign words[0] = opnd_a;
    assign words[1] = opnd_b;
    assign words[2] = opnd_c;
    assign clses[0] = cls_a;
    assign clses[1] = cls_b;
    assign clses[2] = cls_c;

    assign is_two   = (op_count == 2'd2);
    assign is_three = (op_count == 2'd3);
    assign in_use   = {is_three, is_two | is_three, 1'b1};

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_sig
        assign sig_hit[i] = in_use[i] & cls_is_snan(clses[i]);
    end

    assign invalid_out = (|sig_hit) | (is_three & inf_zero);

    fpnan_pick2 #(.FRAC_W(FRAC_W)) u_pick2 (
        .sign_a (opnd_a[WORD_W-1]),
        .frac_a (opnd_a[FRAC_W-1:0]),
        .cls_a  (cls_a),
        .sign_b (opnd_b[WORD_W-1]),
        .frac_b (opnd_b[FRAC_W-1:0]),
        .cls_b  (cls_b),
        .sel    (sel2)
    );

    fpnan_pick3 u_pick3 (
        .cls_a    (cls_a),
        .cls_b    (cls_b),
        .cls_c    (cls_c),
        .inf_zero (inf_zero),
        .sel      (sel3)
    );

    always_comb begin
        if (is_three)    sel = sel3;
        else if (is_two) sel = sel2;
        else             sel = PICK_A;
        case (sel)
            PICK_B:  begin chosen_word = words[1]; chosen_cls = clses[1]; end
            PICK_C:  begin chosen_word = words[2]; chosen_cls = clses[2]; end
            default: begin chosen_word = words[0]; chosen_cls = clses[0]; end
        endcase
    end

    fpnan_finish #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_finish (
        .word_in    (chosen_word),
        .cls_in     (chosen_cls),
        .force_dflt (dflt_mode | (sel == PICK_DFLT)),
        .word_out   (nan_out)
    );
endmodule

// File: rtl/fpnan_select_chk.sv
module fpnan_select_chk
    import fpnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic [1:0]        op_count,
    input logic [WORD_W-1:0] opnd_a,
    input logic [WORD_W-1:0] opnd_b,
    input logic [WORD_W-1:0] opnd_c,
    input logic [2:0]        cls_a,
    input logic [2:0]        cls_b,
    input logic [2:0]        cls_c,
    input logic              dflt_mode,
    input logic              inf_zero,
    input logic [WORD_W-1:0] nan_out,
    input logic              invalid_out
);
    localparam logic [WORD_W-1:0] DFLT =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    logic three, any_nan;

    always_comb begin
        three   = (op_count == 2'd3);
        any_nan = cls_is_nan(cls_a)
                | ((op_count >= 2'd2) & cls_is_nan(cls_b))
                | (three & cls_is_nan(cls_c));
        // R3: default mode gives the canonical NaN whenever the unit is active
        if (any_nan || three) begin
            a_r3_dflt_mode: assert (!dflt_mode || nan_out == DFLT)
                else $error("a_r3_dflt_mode");
        end
        // R8: inf times zero forces default NaN and invalid
        a_r8_inf_zero: assert (!(three && inf_zero) || (nan_out == DFLT && invalid_out))
            else $error("a_r8_inf_zero");
        // R9: addend NaN wins in three-operand mode
        a_r9_addend: assert (!(three && !inf_zero && !dflt_mode && cls_is_nan(cls_c))
                             || nan_out == (opnd_c | (WORD_W'(1) << (FRAC_W - 1))))
            else $error("a_r9_addend");
        // R7: any NaN result is quiet
        a_r7_quiet: assert (!(any_nan || three) || nan_out[FRAC_W-1])
            else $error("a_r7_quiet");
        // R1: a signalling operand in use always raises invalid
        a_r1_sig_invalid: assert (!cls_is_snan(cls_a) || invalid_out)
            else $error("a_r1_sig_invalid");
    end
endmodule

bind fpnan_select fpnan_select_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .op_count    (op_count),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .opnd_c      (opnd_c),
    .cls_a       (cls_a),
    .cls_b       (cls_b),
    .cls_c       (cls_c),
    .dflt_mode   (dflt_mode),
    .inf_zero    (inf_zero),
    .nan_out     (nan_out),
    .invalid_out (invalid_out)
);

// File: tb/tb_fpnan_select.sv
module tb_fpnan_select;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]  op_count;
    logic [31:0] opnd_a, opnd_b, opnd_c;
    logic [2:0]  cls_a, cls_b, cls_c;
    logic        dflt_mode, inf_zero;
    logic [31:0] nan_out;
    logic        invalid_out;

    int checks = 0;
    int fails  = 0;

    fpnan_select dut (
        .op_count(op_count), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .cls_a(cls_a), .cls_b(cls_b), .cls_c(cls_c),
        .dflt_mode(dflt_mode), .inf_zero(inf_zero),
        .nan_out(nan_out), .invalid_out(invalid_out)
    );

    function automatic logic [31:0] build(input int c, input int p, input logic s);
        logic [22:0] pay;
        pay = (p == 0) ? 23'h000003 : 23'h000011;
        case (c)
            0: return {s, 8'h00, 23'h0};
            1: return {s, 8'h40, pay};
            2: return {s, 8'hFF, 23'h0};
            3: return {s, 8'hFF, pay | 23'h400000};
            default: return {s, 8'hFF, pay};
        endcase
    endfunction

    function automatic logic nanc(input int c); return c >= 3; endfunction
    function automatic logic sigc(input int c); return c == 4; endfunction

    task automatic check_word(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: nan_out actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: invalid_out actual %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        op_count = 2'd1; opnd_a = '0; opnd_b = '0; opnd_c = '0;
        cls_a = '0; cls_b = '0; cls_c = '0; dflt_mode = 0; inf_zero = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        for (int ar = 1; ar <= 3; ar++)
        for (int dm = 0; dm < 2; dm++)
        for (int iz = 0; iz < 2; iz++)
        for (int ca = 0; ca < 5; ca++)
        for (int cb = 0; cb < 5; cb++)
        for (int cc = 0; cc < 5; cc++)
        for (int pa = 0; pa < 2; pa++)
        for (int pb = 0; pb < 2; pb++)
        for (int sa = 0; sa < 2; sa++)
        for (int sb = 0; sb < 2; sb++) begin
            logic [31:0] wa, wb, wc, expw;
            logic [25:0] ka, kb;
            logic run, expi;
            string tag, itag;
            wa = build(ca, pa, sa[0]);
            wb = build(cb, pb, sb[0]);
            wc = build(cc, pa ^ pb, sa[0] ^ sb[0]);
            @(negedge clk);
            op_count = 2'(ar); opnd_a = wa; opnd_b = wb; opnd_c = wc;
            cls_a = 3'(ca); cls_b = 3'(cb); cls_c = 3'(cc);
            dflt_mode = dm[0]; inf_zero = iz[0];
            #1;
            run  = nanc(ca) | (ar >= 2 && nanc(cb)) | (ar == 3);
            expi = sigc(ca) | (ar >= 2 && sigc(cb)) | (ar == 3 && (sigc(cc) || iz == 1));
            itag = (ar == 3 && iz == 1) ? "R8" : (ar == 1 && sigc(cb)) ? "R12" : "R1";
            expw = 32'h7FC00000;
            if (ar == 1) begin
                expw = wa | 32'h00400000;
                tag  = (nanc(cb) || nanc(cc)) ? "R12" : "R2";
            end else if (ar == 2) begin
                ka = {nanc(ca), sigc(ca), wa[22:0], ~wa[31]};
                kb = {nanc(cb), sigc(cb), wb[22:0], ~wb[31]};
                expw = ((ka >= kb) ? wa : wb) | 32'h00400000;
                if (nanc(cc))                               tag = "R12";
                else if (!(nanc(ca) && nanc(cb)) || ca != cb) tag = "R4";
                else if (wa[22:0] != wb[22:0])              tag = "R5";
                else if (wa[31] != wb[31])                  tag = "R6";
                else                                        tag = "R7";
                if (tag == "R4" && sigc(ca) && sigc(cb)) tag = "R7";
            end else begin
                if (iz == 1)       begin expw = 32'h7FC00000; tag = "R8"; end
                else if (nanc(cc)) begin expw = wc | 32'h00400000; tag = "R9"; end
                else if (sigc(ca)) begin expw = wa | 32'h00400000; tag = "R10"; end
                else if (sigc(cb)) begin expw = wb | 32'h00400000; tag = "R10"; end
                else if (nanc(ca)) begin expw = wa; tag = "R10"; end
                else if (nanc(cb)) begin expw = wb; tag = "R10"; end
                else               begin expw = 32'h7FC00000; tag = "R11"; end
            end
            if (dm == 1) begin
                expw = 32'h7FC00000;
                tag  = "R3";
            end
            if (run) check_word(tag, nan_out, expw);
            check_bit(itag, invalid_out, expi);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule